// File: doc/BRIEF.md
# Idle Mode Power Controller

This block steps a small processor core into a low-power idle state and back out of it. A one-cycle power-save strobe from the core starts entry. During entry the controller removes the CPU clock enable and sends a single-cycle clear pulse to the watchdog. The system clock and the peripheral clocks keep running throughout. Once idle, the controller waits for a wake event: a pending interrupt whose enable bit is set, a device reset event, or a watchdog time-out. On wake it restores the CPU clock enable at once.

An interrupt that arrives with the power-save strobe, or during the one entry cycle, does not cancel entry. It is remembered, idle is entered fully, and the core then wakes in the first idle cycle. Each wake is recorded in a three-bit cause register that software clears by writing ones. The low-power RC oscillator enable follows the watchdog and clock-monitor enables, so it stays on during idle whenever either of them is active.

Top module: `idle_power_ctrl`

## Requirements
- R1: After reset `cpu_clk_en`=1, `sys_clk_en`=1, `periph_clk_en`=1, `wdt_clr`=0, `in_idle`=0 and `wake_cause`=0.
- R2: A `pwr_save` pulse sampled in the run state drops `cpu_clk_en` and raises `wdt_clr` in the next cycle. `wdt_clr` stays high for exactly one cycle.
- R3: The entry phase lasts one cycle. `in_idle` rises in the cycle after `wdt_clr`, unless a reset event was sampled during entry.
- R4: While idle with no wake event, `cpu_clk_en` stays 0 and `sys_clk_en` and `periph_clk_en` stay 1.
- R5: In idle, a pending interrupt bit `i` with `irq_en[i]`=1 returns the block to run in the next cycle (`cpu_clk_en`=1, `in_idle`=0) and sets `wake_cause` bit 0. A pending interrupt whose enable bit is 0 has no effect.
- R6: In idle, `wdt_timeout` wakes the block in the next cycle and sets `wake_cause` bit 2.
- R7: A `rst_evt` sampled during entry or idle returns the block to run in the next cycle and sets only `wake_cause` bit 1, even when other wake sources are present in the same cycle. In the run state, `rst_evt` blocks a coincident `pwr_save`.
- R8: An enabled interrupt sampled with `pwr_save` or during entry does not cancel entry. Idle is reached, and the block wakes after exactly one idle cycle with `wake_cause` bit 0 set, even if the interrupt has already gone away.
- R9: `lprc_en` equals `wdt_on` OR `fscm_on`, idle included.
- R10: A one in `cause_clr` clears the matching `wake_cause` bit in the next cycle. A wake that sets a bit in the same cycle wins over the clear.
- R11: `pwr_save` during entry or idle has no effect. A `wdt_timeout` during entry is ignored, because the watchdog is being cleared then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_save | input | 1 | Power-save instruction strobe from the core |
| irq_pend | input | N_IRQ | Pending interrupt flags |
| irq_en | input | N_IRQ | Per-interrupt enable bits |
| rst_evt | input | 1 | Device reset event (wake source) |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_on | input | 1 | Watchdog is enabled |
| fscm_on | input | 1 | Clock monitor is enabled |
| cause_clr | input | 3 | Write-one-to-clear strobe for `wake_cause` |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock source enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| in_idle | output | 1 | Block is in the idle state |
| wake_cause | output | 3 | Bit0 interrupt, bit1 reset, bit2 watchdog |

## Verification
A wrong state register shows up at the ports within one cycle. `cpu_clk_en`, `wdt_clr` and `in_idle` are decoded from it, so a stuck entry phase gives a `wdt_clr` wider than one cycle, and a missed wake leaves `cpu_clk_en` low in the cycle after the event. A lost deferred-interrupt flag shows as the block staying idle one cycle after entry. A wrong priority or a wrong clear order shows as the wrong bit pattern in `wake_cause` in the cycle after the wake.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_IRQ = 0;
    localparam int CAUSE_RST = 1;
    localparam int CAUSE_WDT = 2;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_ENTER = 2'd1,
        PS_IDLE  = 2'd2
    } pstate_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_IRQ  = 2'd1,
        WK_WDT  = 2'd2,
        WK_RST  = 2'd3
    } wake_e;

    typedef struct packed {
        pstate_e st;
        logic    held;
    } ctl_s;

endpackage

// File: rtl/idle_wake_arb.sv
module idle_wake_arb
    import idle_pwr_pkg::*;
#(
    parameter int N_IRQ = 16
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             held,
    input  logic             rst_evt,
    input  logic             wdt_to,
    output logic             any_irq,
    output wake_e            wake
);

    logic [N_IRQ-1:0] masked;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_mask
        assign masked[g] = irq_pend[g] & irq_en[g];
    end

    assign any_irq = |masked;

    // fixed priority: reset, then watchdog, then interrupt
    always_comb begin
        if (rst_evt)              wake = WK_RST;
        else if (wdt_to)          wake = WK_WDT;
        else if (any_irq || held) wake = WK_IRQ;
        else                      wake = WK_NONE;
    end

endmodule

// File: rtl/idle_cause_reg.sv
module idle_cause_reg
    import idle_pwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic [CAUSE_W-1:0] clr_vec,
    output logic [CAUSE_W-1:0] cause
);

    logic [CAUSE_W-1:0] cause_d, cause_q;

    always_comb begin
        cause_d = (cause_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause = cause_q;

    // R10: a set in the same cycle overrides the clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & clr_vec)) |=> ((cause & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

endmodule

// File: rtl/idle_power_ctrl.sv
module idle_power_ctrl
    import idle_pwr_pkg::*;
#(
    parameter int N_IRQ = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_save,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             rst_evt,
    input  logic             wdt_timeout,
    input  logic             wdt_on,
    input  logic             fscm_on,
    input  logic [2:0]       cause_clr,
    output logic             cpu_clk_en,
    output logic             sys_clk_en,
    output logic             periph_clk_en,
    output logic             lprc_en,
    output logic             wdt_clr,
    output logic             in_idle,
    output logic [2:0]       wake_cause
);

    ctl_s               ctl_d, ctl_q;
    logic [CAUSE_W-1:0] set_vec;
    logic               any_irq;
    wake_e              wake;

    idle_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .held     (ctl_q.held),
        .rst_evt  (rst_evt),
        .wdt_to   (wdt_timeout),
        .any_irq  (any_irq),
        .wake     (wake)
    );

    always_comb begin
        ctl_d   = ctl_q;
        set_vec = '0;
        unique case (ctl_q.st)
            PS_RUN: begin
                ctl_d.held = 1'b0;
                if (pwr_save && !rst_evt) begin
                    ctl_d.st   = PS_ENTER;
                    ctl_d.held = any_irq;
                end
            end
            PS_ENTER: begin
                if (rst_evt) begin
                    ctl_d.st           = PS_RUN;
                    ctl_d.held         = 1'b0;
                    set_vec[CAUSE_RST] = 1'b1;
                end else begin
                    ctl_d.st   = PS_IDLE;
                    ctl_d.held = ctl_q.held | any_irq;
                end
            end
            PS_IDLE: begin
                unique case (wake)
                    WK_RST: set_vec[CAUSE_RST] = 1'b1;
                    WK_WDT: set_vec[CAUSE_WDT] = 1'b1;
                    WK_IRQ: set_vec[CAUSE_IRQ] = 1'b1;
                    default: ;
                endcase
                if (wake != WK_NONE) begin
                    ctl_d.st   = PS_RUN;
                    ctl_d.held = 1'b0;
                end
            end
            default: begin
                ctl_d.st   = PS_RUN;
                ctl_d.held = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: PS_RUN, held: 1'b0};
        else        ctl_q <= ctl_d;
    end

    idle_cause_reg u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (cause_clr),
        .cause   (wake_cause)
    );

    assign cpu_clk_en    = (ctl_q.st == PS_RUN);
    assign wdt_clr       = (ctl_q.st == PS_ENTER);
    assign in_idle       = (ctl_q.st == PS_IDLE);
    assign sys_clk_en    = 1'b1;
    assign periph_clk_en = 1'b1;
    assign lprc_en       = wdt_on | fscm_on;

    // R2: the clear pulse lasts one cycle
    a_r2_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);

    // R3: entry finishes in one cycle unless a reset event intervenes
    a_r3_enter_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr && !rst_evt) |=> in_idle);

    // R4: the CPU never runs while idle
    a_r4_idle_gates_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> (!cpu_clk_en && sys_clk_en && periph_clk_en));

    // R5: an enabled interrupt alone wakes from idle and records its cause
    a_r5_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && (|(irq_pend & irq_en)) && !rst_evt && !wdt_timeout)
        |=> (cpu_clk_en && wake_cause[CAUSE_IRQ]));

    // R7: a reset event out of entry or idle wins over the other sources
    a_r7_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && rst_evt) |=> (cpu_clk_en && wake_cause[CAUSE_RST]));

    // R8: a deferred interrupt causes a wake in the first idle cycle
    a_r8_deferred_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && ctl_q.held) |=> cpu_clk_en);

endmodule

// File: tb/idle_power_ctrl_test.sv
module idle_power_ctrl_test;

    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_save = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic [NI-1:0] irq_en = '0;
    logic          rst_evt = 1'b0;
    logic          wdt_timeout = 1'b0;
    logic          wdt_on = 1'b0;
    logic          fscm_on = 1'b0;
    logic [2:0]    cause_clr = '0;
    logic          cpu_clk_en, sys_clk_en, periph_clk_en, lprc_en, wdt_clr, in_idle;
    logic [2:0]    wake_cause;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    idle_power_ctrl #(.N_IRQ(NI)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_save(pwr_save), .irq_pend(irq_pend),
        .irq_en(irq_en), .rst_evt(rst_evt), .wdt_timeout(wdt_timeout),
        .wdt_on(wdt_on), .fscm_on(fscm_on), .cause_clr(cause_clr),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en),
        .periph_clk_en(periph_clk_en), .lprc_en(lprc_en), .wdt_clr(wdt_clr),
        .in_idle(in_idle), .wake_cause(wake_cause)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        cause_clr = 3'b111;
        tick();
        cause_clr = 3'b000;
        check("R10 clear all", 32'(wake_cause), 32'd0);
    endtask

    task automatic enter_idle();
        pwr_save = 1'b1;
        tick();
        pwr_save = 1'b0;
        check("R2 cpu gated on entry", 32'(cpu_clk_en), 32'd0);
        check("R2 wdt clear pulse", 32'(wdt_clr), 32'd1);
        tick();
        check("R3 idle after one cycle", 32'(in_idle), 32'd1);
        check("R2 pulse one cycle", 32'(wdt_clr), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check("R1 cpu_clk_en", 32'(cpu_clk_en), 32'd1);
        check("R1 wdt_clr", 32'(wdt_clr), 32'd0);
        check("R1 in_idle", 32'(in_idle), 32'd0);
        check("R1 cause", 32'(wake_cause), 32'd0);
        check("R1 clocks", 32'({sys_clk_en, periph_clk_en}), 32'd3);
        rst_n = 1'b1;
        tick();

        // R5 sweep: every enable mask against every single interrupt source
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < NI; i++) begin
                irq_en = 4'(m);
                enter_idle();
                irq_pend = 4'(1 << i);
                tick();
                irq_pend = '0;
                check("R5 wake on enabled irq", 32'(cpu_clk_en), 32'(m[i]));
                check("R5 cause irq", 32'(wake_cause), 32'(m[i]));
                if (!m[i]) begin
                    check("R4 stays idle", 32'(in_idle), 32'd1);
                    rst_evt = 1'b1;
                    tick();
                    rst_evt = 1'b0;
                    check("R7 reset exit", 32'(wake_cause), 32'd2);
                end
                clear_all();
            end
        end
        irq_en = 4'hF;

        // R4 / R9 / R11: idle holds, oscillator enable follows its sources
        enter_idle();
        for (int k = 0; k < 4; k++) begin
            wdt_on = k[0];
            fscm_on = k[1];
            pwr_save = 1'b1;
            tick();
            pwr_save = 1'b0;
            check("R4 idle held", 32'({cpu_clk_en, in_idle, sys_clk_en, periph_clk_en}), 32'h7);
            check("R11 strobe in idle ignored", 32'(in_idle), 32'd1);
            check("R9 lprc_en", 32'(lprc_en), 32'(k != 0));
        end
        wdt_on = 1'b0;
        fscm_on = 1'b0;

        // R6: watchdog time-out wakes
        wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
        check("R6 wake on wdt", 32'(cpu_clk_en), 32'd1);
        check("R6 cause wdt", 32'(wake_cause), 32'd4);
        clear_all();

        // R7: all sources at once, reset alone recorded
        enter_idle();
        rst_evt = 1'b1;
        wdt_timeout = 1'b1;
        irq_pend = 4'h1;
        tick();
        rst_evt = 1'b0;
        wdt_timeout = 1'b0;
        irq_pend = '0;
        check("R7 reset priority", 32'(wake_cause), 32'd2);
        check("R7 running", 32'(cpu_clk_en), 32'd1);
        clear_all();

        // R7: reset during entry aborts entry
        pwr_save = 1'b1;
        tick();
        pwr_save = 1'b0;
        rst_evt = 1'b1;
        tick();
        rst_evt = 1'b0;
        check("R7 reset in entry", 32'({cpu_clk_en, in_idle}), 32'h2);
        check("R7 reset cause", 32'(wake_cause), 32'd2);
        clear_all();

        // R7: reset with strobe in run blocks entry
        pwr_save = 1'b1;
        rst_evt = 1'b1;
        tick();
        pwr_save = 1'b0;
        rst_evt = 1'b0;
        check("R7 entry blocked", 32'({cpu_clk_en, wdt_clr}), 32'h2);

        // R8: interrupt pulse coincident with strobe
        pwr_save = 1'b1;
        irq_pend = 4'h2;
        tick();
        pwr_save = 1'b0;
        irq_pend = '0;
        check("R8 entry not cancelled", 32'(wdt_clr), 32'd1);
        tick();
        check("R8 idle reached", 32'(in_idle), 32'd1);
        tick();
        check("R8 deferred wake", 32'(cpu_clk_en), 32'd1);
        check("R8 cause irq", 32'(wake_cause), 32'd1);
        clear_all();

        // R8: interrupt pulse during entry
        pwr_save = 1'b1;
        tick();
        pwr_save = 1'b0;
        irq_pend = 4'h8;
        tick();
        irq_pend = '0;
        check("R8 idle reached late irq", 32'(in_idle), 32'd1);
        tick();
        check("R8 late deferred wake", 32'(cpu_clk_en), 32'd1);
        clear_all();

        // R11: watchdog time-out during entry ignored
        pwr_save = 1'b1;
        tick();
        pwr_save = 1'b0;
        wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
        check("R11 wdt in entry ignored", 32'(in_idle), 32'd1);
        tick();
        check("R11 still idle", 32'({in_idle, wake_cause}), 32'h8);

        // R10: set wins over clear, other bits untouched
        irq_pend = 4'h4;
        cause_clr = 3'b001;
        tick();
        irq_pend = '0;
        cause_clr = 3'b000;
        check("R10 set beats clear", 32'(wake_cause), 32'd1);
        cause_clr = 3'b100;
        tick();
        cause_clr = 3'b000;
        check("R10 clear only selected", 32'(wake_cause), 32'd1);
        cause_clr = 3'b001;
        tick();
        cause_clr = 3'b000;
        check("R10 w1c", 32'(wake_cause), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule